// File: doc/BRIEF.md
# Transmit FIFO Controller

This block is the transmit-side word buffer of a synchronous serial port. A host or a DMA engine pushes words into a 16-entry first-in first-out store. The downstream shift register pops them in the order they arrived. The block keeps a 5-bit fill count and compares it against a programmable 4-bit watermark. From that comparison it maintains a "transmit room" flag, which only hardware can set.

The flag is gated by an interrupt enable. A routing bit then sends the gated request either to a DMA request line or to the CPU interrupt line. Transfer-complete events from the shifter always go to the CPU line.

A control register holds the enables and the port mode bits. Some of those bits are write-protected while the port is running. A separate FIFO control write loads the watermark and can empty the FIFO at once.

Top module: `txq_ctrl`

## Requirements
- R1: The fill count `fill_cnt` runs from 0 to 16. A value of 16 (binary 10000) means the FIFO is full, and the count never exceeds 16.
- R2: `pop_valid` is 1 exactly when the count is non-zero. `pop_data` always shows the oldest stored word. A cycle with `pop_rdy`=1 and `pop_valid`=1 removes that word, so words leave in the order they were written.
- R3: A write while the count is 16 is discarded and the count stays at 16. This holds even if a pop happens in the same cycle, in which case the count drops to 15. Such a write sets `ovf_err`, which stays at 1 until reset or a FIFO clear.
- R4: A write (`wr_en`=1) while control bit 0 (transmit enable) is 0 is ignored. It changes neither the count nor `ovf_err`.
- R5: An accepted write and a pop in the same cycle leave the count unchanged. Word order is kept.
- R6: `empty_flag` is set when a pop leaves a count less than or equal to the watermark. Apart from reset and FIFO clear, nothing else sets it, and no register write can set it.
- R7: `empty_flag` clears when an accepted write, with no pop in that cycle, leaves a count above the watermark.
- R8: The request is active only while `empty_flag`=1 and control bit 2 (room interrupt enable) is 1. With bit 2 at 0, `dma_req` stays at 0, and the flag adds nothing to `cpu_irq`.
- R9: With control bit 4 (DMA routing) at 1, the request appears on `dma_req`, and `cpu_irq` equals control bit 3 (completion interrupt enable) AND `xfer_done`. With bit 4 at 0, `dma_req` stays at 0 and `cpu_irq` is the request OR'd with (bit 3 AND `xfer_done`).
- R10: A `fcr_we` write with bit 0 at 1 empties the FIFO, clears `ovf_err` and sets `empty_flag`. Every `fcr_we` write loads the watermark from `fcr_wdata[7:4]`. A reset also empties the FIFO and sets `empty_flag`, with a watermark of 0.
- R11: Control bits 4 (DMA routing), 5 (serial enable), 6 (mode select) and 7 (data length) change only when bit 0 (transmit enable) and bit 1 (receive enable) both hold 0 before the write. Bits 0 to 3 are always writable.
- R12: The control register resets to 0x0000, and its bits 15 to 8 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write value |
| ctl_rdata | output | 16 | Control register contents |
| fcr_we | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | Bit 0 clears the FIFO; bits 7:4 are the watermark |
| wmark | output | 4 | Current watermark |
| wr_en | input | 1 | Push a word |
| wr_data | input | 16 | Word to push |
| pop_rdy | input | 1 | Shifter takes the oldest word |
| pop_valid | output | 1 | A word is available |
| pop_data | output | 16 | Oldest stored word |
| fill_cnt | output | 5 | Number of stored words |
| empty_flag | output | 1 | Fill at or below watermark after a pop |
| ovf_err | output | 1 | Sticky write-while-full error |
| xfer_done | input | 1 | Transfer-complete event from the shifter |
| dma_req | output | 1 | Request to the DMA engine |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench sweeps every watermark value through a full fill, one overflowing write and a full drain. At each step it compares the flag against an arithmetic model. A design that tested the watermark with "<" instead of "<=", or with the count before the pop, would show the flag one word late. The bench also hits a write that lands on a full FIFO in the same cycle as a pop. A design that let the pop make room for the write would store the word and leave `ovf_err` clear. A steady run of simultaneous push and pop checks that the count neither creeps nor loses data. An exhaustive routing table checks that the request is never sent to both lines.

// File: rtl/txq_pkg.sv
// Shared types for the transmit FIFO controller.
// Assumes the control register fields sit in bits 7:0; bits 15:8 are reserved.
package txq_pkg;
    localparam int CTL_W = 16;

    // Control register fields; the declaration order fixes bit positions 7 down to 0.
    typedef struct packed {
        logic wide;      // bit 7: data length select (protected)
        logic mode_sel;  // bit 6: transfer mode select (protected)
        logic ser_en;    // bit 5: serial enable (protected)
        logic dma_mode;  // bit 4: route room request to DMA (protected)
        logic tc_ie;     // bit 3: completion interrupt enable
        logic room_ie;   // bit 2: room interrupt enable
        logic rx_en;     // bit 1: receive enable
        logic tx_en;     // bit 0: transmit enable
    } txq_ctl_t;

    localparam int CTL_USED = $bits(txq_ctl_t);
endpackage

// File: rtl/txq_ctlreg.sv
// Control register with run-time write protection.
// Writes to the mode group (bits 7:4) only land when both enables currently read 0.
// Assumes one write strobe per cycle; reserved bits read as zero.
module txq_ctlreg
    import txq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output txq_ctl_t         ctl,
    output logic [CTL_W-1:0] rdata
);
    txq_ctl_t wr_val;
    logic     idle;

    // Purpose: view the incoming write as the field struct.
    assign wr_val = txq_ctl_t'(wdata[CTL_USED-1:0]);
    // Purpose: the protected group may change only while the port is stopped.
    assign idle   = !ctl.tx_en && !ctl.rx_en;

    // Purpose: hold the register, applying protection per field group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (we) begin
            ctl.tx_en   <= wr_val.tx_en;
            ctl.rx_en   <= wr_val.rx_en;
            ctl.room_ie <= wr_val.room_ie;
            ctl.tc_ie   <= wr_val.tc_ie;
            if (idle) begin
                ctl.dma_mode <= wr_val.dma_mode;
                ctl.ser_en   <= wr_val.ser_en;
                ctl.mode_sel <= wr_val.mode_sel;
                ctl.wide     <= wr_val.wide;
            end
        end
    end

    // Purpose: read path with reserved bits forced low.
    assign rdata = {{(CTL_W-CTL_USED){1'b0}}, ctl};
endmodule

// File: rtl/txq_store.sv
// Word storage, pointers, fill count and sticky overflow for the transmit FIFO.
// Assumes push_req is already qualified by transmit enable; a clear wins over push and pop.
// A push into a full store is dropped even when a pop happens in the same cycle.
module txq_store #(
    parameter  int DW    = 16,
    parameter  int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push_req,
    input  logic [DW-1:0] wr_data,
    input  logic          pop_req,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          ovf
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW-1:0] wr_ptr_inc, rd_ptr_inc;
    logic          full;

    // Purpose: pointer advance, natural wrap for power-of-two depths, compare otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_ptr_inc = wr_ptr + 1'b1;
            assign rd_ptr_inc = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_ptr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Purpose: accept or refuse this cycle's push and pop.
    assign full     = (count == CW'(DEPTH));
    assign rd_valid = (count != '0);
    assign push_ok  = push_req && !full && !clr;
    assign pop_ok   = pop_req && rd_valid && !clr;

    // Purpose: next fill count from the accepted operations.
    always_comb begin
        if (clr) begin
            count_nxt = '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   count_nxt = count + 1'b1;
                2'b01:   count_nxt = count - 1'b1;
                default: count_nxt = count;
            endcase
        end
    end

    // Purpose: write the accepted word into its slot.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Purpose: pointers, count and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr_inc;
            if (pop_ok)  rd_ptr <= rd_ptr_inc;
            count <= count_nxt;
            if (push_req && full) ovf <= 1'b1;
        end
    end

    // Purpose: oldest word to the shifter.
    assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/txq_mark.sv
// Watermark register and hardware-only room flag.
// The flag rises after a pop whose resulting count is at or below the watermark,
// and falls after a lone push whose resulting count exceeds it.
// Assumes count_nxt already reflects the accepted push and pop of the cycle.
module txq_mark #(
    parameter int CW  = 5,
    parameter int WMW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           wm_we,
    input  logic [WMW-1:0] wm_wdata,
    input  logic           pushed,
    input  logic           popped,
    input  logic [CW-1:0]  count_nxt,
    output logic [WMW-1:0] wm,
    output logic           flag
);
    logic at_or_below;

    // Purpose: compare the post-operation count with the watermark.
    assign at_or_below = (count_nxt <= CW'(wm));

    // Purpose: hold the watermark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm <= '0;
        end else if (wm_we) begin
            wm <= wm_wdata;
        end
    end

    // Purpose: set and clear the room flag from hardware events only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b1;
        end else if (popped && at_or_below) begin
            flag <= 1'b1;
        end else if (pushed && !popped && !at_or_below) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/txq_route.sv
// Gates the room request and steers it to the DMA line or the CPU line.
// Completion events always go to the CPU line.
// Purely combinational; assumes registered inputs.
module txq_route (
    input  logic flag,
    input  logic room_ie,
    input  logic tc_ie,
    input  logic dma_mode,
    input  logic done,
    output logic dma_req,
    output logic cpu_irq
);
    logic room_req;
    logic done_req;

    // Purpose: enable gating and destination select.
    assign room_req = flag && room_ie;
    assign done_req = done && tc_ie;
    assign dma_req  = room_req && dma_mode;
    assign cpu_irq  = (room_req && !dma_mode) || done_req;
endmodule

// File: rtl/txq_ctrl.sv
// Transmit FIFO controller top: control register, word store, watermark flag
// and request routing. Writes are accepted only while transmit enable is set.
// Assumes a single clock domain and a synchronous active-low reset.
module txq_ctrl
    import txq_pkg::*;
#(
    parameter  int DW    = 16,
    parameter  int DEPTH = 16,
    localparam int WMW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int FCR_W = WMW + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             fcr_we,
    input  logic [FCR_W-1:0] fcr_wdata,
    output logic [WMW-1:0]   wmark,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             pop_rdy,
    output logic             pop_valid,
    output logic [DW-1:0]    pop_data,
    output logic [CW-1:0]    fill_cnt,
    output logic             empty_flag,
    output logic             ovf_err,
    input  logic             xfer_done,
    output logic             dma_req,
    output logic             cpu_irq
);
    txq_ctl_t      ctl;
    logic          clr;
    logic          push_ok, pop_ok;
    logic [CW-1:0] count_nxt;

    // Purpose: FIFO clear strobe from bit 0 of the FIFO control write.
    assign clr = fcr_we && fcr_wdata[0];

    txq_ctlreg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl),
        .rdata (ctl_rdata)
    );

    txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push_req  (wr_en && ctl.tx_en),
        .wr_data   (wr_data),
        .pop_req   (pop_rdy),
        .rd_data   (pop_data),
        .rd_valid  (pop_valid),
        .count     (fill_cnt),
        .count_nxt (count_nxt),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .ovf       (ovf_err)
    );

    txq_mark #(.CW(CW), .WMW(WMW)) u_mark (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wm_we     (fcr_we),
        .wm_wdata  (fcr_wdata[FCR_W-1:4]),
        .pushed    (push_ok),
        .popped    (pop_ok),
        .count_nxt (count_nxt),
        .wm        (wmark),
        .flag      (empty_flag)
    );

    txq_route u_route (
        .flag     (empty_flag),
        .room_ie  (ctl.room_ie),
        .tc_ie    (ctl.tc_ie),
        .dma_mode (ctl.dma_mode),
        .done     (xfer_done),
        .dma_req  (dma_req),
        .cpu_irq  (cpu_irq)
    );
endmodule

// File: rtl/txq_ctrl_chk.sv
// Property checker for txq_ctrl, attached by bind. Observes top-level ports only.
module txq_ctrl_chk #(
    parameter  int DEPTH = 16,
    localparam int WMW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int FCR_W = WMW + 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [15:0]      ctl_rdata,
    input logic             fcr_we,
    input logic [FCR_W-1:0] fcr_wdata,
    input logic [WMW-1:0]   wmark,
    input logic             wr_en,
    input logic             pop_rdy,
    input logic             pop_valid,
    input logic [CW-1:0]    fill_cnt,
    input logic             empty_flag,
    input logic             ovf_err,
    input logic             xfer_done,
    input logic             dma_req,
    input logic             cpu_irq
);
    logic clr, tx_en, rx_en, room_ie, tc_ie, dma_mode, fire;
    assign clr      = fcr_we && fcr_wdata[0];
    assign tx_en    = ctl_rdata[0];
    assign rx_en    = ctl_rdata[1];
    assign room_ie  = ctl_rdata[2];
    assign tc_ie    = ctl_rdata[3];
    assign dma_mode = ctl_rdata[4];
    assign fire     = pop_rdy && pop_valid;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));

    p_pop_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !wr_en && !clr |=> fill_cnt == $past(fill_cnt) - 1'b1);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt == CW'(DEPTH) && wr_en && tx_en && !pop_rdy && !clr
        |=> fill_cnt == CW'(DEPTH) && ovf_err);

    p_txoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !tx_en && !fire && !clr |=> $stable(fill_cnt));

    p_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && tx_en && fire && fill_cnt != CW'(DEPTH) && !clr |=> $stable(fill_cnt));

    p_flag_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_flag) |-> $past(fire) || $past(clr));

    p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && tx_en && !pop_rdy && !clr && fill_cnt < CW'(DEPTH)
        && ({1'b0, fill_cnt} + 1'b1) > (CW + 1)'(wmark) |=> !empty_flag);

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(room_ie && empty_flag) |-> !dma_req);

    p_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_mode |-> cpu_irq == (tc_ie && xfer_done));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> fill_cnt == '0 && !ovf_err && empty_flag);

    p_protect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && (tx_en || rx_en) |=> ctl_rdata[7:4] == $past(ctl_rdata[7:4]));

    p_rsvd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[15:8] == 8'h00);
endmodule

bind txq_ctrl txq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_rdata  (ctl_rdata),
    .fcr_we     (fcr_we),
    .fcr_wdata  (fcr_wdata),
    .wmark      (wmark),
    .wr_en      (wr_en),
    .pop_rdy    (pop_rdy),
    .pop_valid  (pop_valid),
    .fill_cnt   (fill_cnt),
    .empty_flag (empty_flag),
    .ovf_err    (ovf_err),
    .xfer_done  (xfer_done),
    .dma_req    (dma_req),
    .cpu_irq    (cpu_irq)
);

// File: tb/sim_txq_ctrl.sv
module sim_txq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int DEPTH      = 16;
    localparam int WMW        = 4;
    localparam int CW         = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0;
    logic [15:0]   ctl_wdata = '0;
    logic [15:0]   ctl_rdata;
    logic          fcr_we = 1'b0;
    logic [7:0]    fcr_wdata = '0;
    logic [WMW-1:0] wmark;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          pop_rdy = 1'b0;
    logic          pop_valid;
    logic [DW-1:0] pop_data;
    logic [CW-1:0] fill_cnt;
    logic          empty_flag, ovf_err;
    logic          xfer_done = 1'b0;
    logic          dma_req, cpu_irq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
        .wmark(wmark), .wr_en(wr_en), .wr_data(wr_data), .pop_rdy(pop_rdy),
        .pop_valid(pop_valid), .pop_data(pop_data), .fill_cnt(fill_cnt),
        .empty_flag(empty_flag), .ovf_err(ovf_err), .xfer_done(xfer_done),
        .dma_req(dma_req), .cpu_irq(cpu_irq)
    );

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    // Reference model state
    int mq[DEPTH];
    int mh = 0, mc = 0, mwm = 0;
    int mflag = 1, movf = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ctl_wr(int v);
        ctl_we = 1'b1;
        ctl_wdata = v[15:0];
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic fifo_clear(int wm);
        fcr_we = 1'b1;
        fcr_wdata = {wm[3:0], 4'b0001};
        tick();
        fcr_we = 1'b0;
        mh = 0; mc = 0; mflag = 1; movf = 0; mwm = wm;
    endtask

    // One cycle of push and/or pop, with model prediction and comparison.
    task automatic cyc(bit w, int d, bit p);
        int pf, pu, ov, nc;
        int txen;
        txen = int'(ctl_rdata[0]);
        if (mc != 0) chk("R2 oldest word", int'(pop_data), mq[mh]);
        pf = (p && mc != 0) ? 1 : 0;
        pu = (w && txen == 1 && mc < DEPTH) ? 1 : 0;
        ov = (w && txen == 1 && mc == DEPTH) ? 1 : 0;
        if (pu == 1) mq[(mh + mc) % DEPTH] = d;
        if (pf == 1) mh = (mh + 1) % DEPTH;
        nc = mc + pu - pf;
        if (pf == 1 && nc <= mwm) mflag = 1;
        else if (pu == 1 && pf == 0 && nc > mwm) mflag = 0;
        if (ov == 1) movf = 1;
        mc = nc;
        wr_en = w; wr_data = d[DW-1:0]; pop_rdy = p;
        tick();
        wr_en = 1'b0; pop_rdy = 1'b0;
        chk("R1 count", int'(fill_cnt), mc);
        chk("R6/R7 flag", int'(empty_flag), mflag);
        chk("R3 ovf", int'(ovf_err), movf);
        chk("R2 valid", int'(pop_valid), (mc != 0) ? 1 : 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R12 / R10 reset state
        chk("R12 ctl reset", int'(ctl_rdata), 0);
        chk("R10 reset count", int'(fill_cnt), 0);
        chk("R10 reset flag", int'(empty_flag), 1);
        chk("R10 reset ovf", int'(ovf_err), 0);
        chk("R10 reset wmark", int'(wmark), 0);
        chk("R2 reset valid", int'(pop_valid), 0);

        // Sweep all watermarks: fill, overflow, drain
        ctl_wr(16'h0001);
        for (int wm = 0; wm < 16; wm++) begin
            fifo_clear(wm);
            chk("R10 wmark load", int'(wmark), wm);
            for (int i = 0; i <= DEPTH; i++) cyc(1'b1, wm * 256 + i, 1'b0);
            chk("R3 full count held", int'(fill_cnt), 16);
            chk("R3 sticky ovf", int'(ovf_err), 1);
            for (int i = 0; i < DEPTH; i++) cyc(1'b0, 0, 1'b1);
            cyc(1'b0, 0, 1'b1);
        end

        // R5: steady push+pop
        fifo_clear(4);
        for (int i = 0; i < 3; i++) cyc(1'b1, 16'h1000 + i, 1'b0);
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, 16'h2000 + i, 1'b1);
            chk("R5 count steady", int'(fill_cnt), 3);
        end
        // R3: write on full with a simultaneous pop
        fifo_clear(2);
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 16'h3000 + i, 1'b0);
        cyc(1'b1, 16'h3fff, 1'b1);
        chk("R3 full+pop count", int'(fill_cnt), 15);
        chk("R3 full+pop ovf", int'(ovf_err), 1);
        for (int i = 0; i < 15; i++) cyc(1'b0, 0, 1'b1);

        // R4: writes ignored while transmit disabled
        fifo_clear(0);
        cyc(1'b1, 16'h4444, 1'b0);
        ctl_wr(16'h0000);
        c0 = int'(fill_cnt);
        for (int i = 0; i < 3; i++) cyc(1'b1, 16'h5000 + i, 1'b0);
        chk("R4 count unchanged", int'(fill_cnt), c0);
        chk("R4 ovf unchanged", int'(ovf_err), 0);

        // R10: clear empties a full FIFO and drops ovf
        ctl_wr(16'h0001);
        for (int i = 0; i < 17; i++) cyc(1'b1, i, 1'b0);
        fifo_clear(7);
        chk("R10 clear count", int'(fill_cnt), 0);
        chk("R10 clear ovf", int'(ovf_err), 0);
        chk("R10 clear flag", int'(empty_flag), 1);
        chk("R10 clear valid", int'(pop_valid), 0);

        // R8 / R9: exhaustive routing table for both flag states
        for (int fs = 1; fs >= 0; fs--) begin
            ctl_wr(16'h0000);
            ctl_wr(16'h0001);
            fifo_clear(0);
            if (fs == 0) cyc(1'b1, 16'h00aa, 1'b0);
            chk("R6/R7 flag setup", int'(empty_flag), fs);
            for (int v = 0; v < 16; v++) begin
                int ie, tc, dm, dn;
                ie = v & 1; tc = (v >> 1) & 1; dm = (v >> 2) & 1; dn = (v >> 3) & 1;
                ctl_wr(16'h0000);
                ctl_wr((dm << 4) | (tc << 3) | (ie << 2));
                xfer_done = dn[0];
                #1;
                chk("R8/R9 dma_req", int'(dma_req), dm & ie & fs);
                chk("R8/R9 cpu_irq", int'(cpu_irq), ((1 - dm) & ie & fs) | (tc & dn));
                xfer_done = 1'b0;
            end
        end

        // R11: protected bits while running
        ctl_wr(16'h0000);
        ctl_wr(16'h0001);
        ctl_wr(16'h00f1);
        chk("R11 protected tx_en", int'(ctl_rdata), 16'h0001);
        ctl_wr(16'h0002);
        ctl_wr(16'h00f2);
        chk("R11 protected rx_en", int'(ctl_rdata), 16'h0002);
        ctl_wr(16'h0000);
        ctl_wr(16'h00f0);
        chk("R11 idle write", int'(ctl_rdata), 16'h00f0);
        // R12: reserved bits read as zero
        ctl_wr(16'h0000);
        ctl_wr(16'hfffc);
        chk("R12 reserved zero", int'(ctl_rdata), 16'h00fc);
        chk("R12 upper byte", int'(ctl_rdata[15:8]), 0);

        done_run = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule